// File: doc/BRIEF.md
# Banked Extended RAM Access Port

This block lets a host reach a battery-backed extended RAM through a byte-wide register bus without mapping the RAM into the host's address space. The host writes a RAM pointer as two bytes (low and high), then moves data through a single data-port register. Every register except the control byte sits behind a bank-select bit, so the pointer, the data port and the burst-enable register are only reachable after the host has switched banks.

When burst mode is enabled, each access to the data port advances the pointer once the access is done, so a block of RAM can be streamed through the port after loading the start address only once. When burst mode is off, repeated data-port accesses keep hitting the same byte. The pointer is as wide as the configured RAM size needs. It wraps to zero past the last byte, and any high-byte bits beyond that width are dropped.

Top module: `xram_port`

## Requirements
- R1: After a synchronous reset the control byte reads 0x00, bank select and burst enable are 0, the RAM pointer is 0 and `rd_data` is 0x00.
- R2: Offset 0x0A is a full 8-bit read/write control byte in either bank, and its bit 4 is the bank-select bit (1 = extended registers visible).
- R3: With bank select at 0, reads of offsets 0x4A, 0x50, 0x51 and 0x53 return 0x00, and writes to them change neither the pointer, the burst enable nor any RAM byte.
- R4: With bank select at 1, offset 0x50 reads and writes pointer bits 7:0 and offset 0x51 reads and writes the pointer bits above 7. High-byte bits beyond the configured pointer width are discarded on write and read back as 0.
- R5: A read strobe samples the addressed value at the clock edge and presents it on `rd_data` from the next cycle on. `rd_data` holds its value in cycles with no read strobe.
- R6: With burst enable at 0, data-port reads and writes leave the pointer unchanged, so repeated accesses hit the same RAM byte.
- R7: With burst enable at 1, each data-port read or write uses the current pointer and then increments it by one.
- R8: A burst increment from the last RAM location (RAM_BYTES-1) wraps the pointer to 0.
- R9: Offset 0x4A (bank 1) holds the burst-enable bit at bit 5. Its other bits read as 0.
- R10: A data-port write in bank 1 stores the byte at the pointer, and a later data-port read at that pointer returns it.
- R11: Reads of any offset not listed above return 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Read data, valid the cycle after the read strobe |

## Verification
The pointer is driven to the top address and then burst-written across the end, which separates a correct wrap from a pointer that runs into dead high bits. A full burst fill of the RAM, followed by single-address reads with burst off, separates auto-increment from a stuck pointer and shows whether each byte landed at its own address. Accesses with bank select at 0, aimed at every banked offset, show whether gating is missing on the read path or on the write path. A long seeded random mix of bank toggles, burst toggles, pointer loads and data-port traffic is compared against a bench model, which catches ordering errors such as incrementing before the access instead of after it.

// File: rtl/xrp_pkg.sv
package xrp_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h0A;
    localparam logic [7:0] OFS_XCFG = 8'h4A;
    localparam logic [7:0] OFS_PLO  = 8'h50;
    localparam logic [7:0] OFS_PHI  = 8'h51;
    localparam logic [7:0] OFS_PORT = 8'h53;

    localparam int BANK_BIT  = 4;
    localparam int BURST_BIT = 5;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_XCFG,
        TGT_PLO,
        TGT_PHI,
        TGT_PORT
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic wr;
        logic rd;
    } acc_t;

    function automatic tgt_e map_offset(input logic [7:0] ofs, input logic bank);
        tgt_e t;
        t = TGT_NONE;
        if (ofs == OFS_CTRL) begin
            t = TGT_CTRL;
        end else if (bank) begin
            unique case (ofs)
                OFS_XCFG: t = TGT_XCFG;
                OFS_PLO:  t = TGT_PLO;
                OFS_PHI:  t = TGT_PHI;
                OFS_PORT: t = TGT_PORT;
                default:  t = TGT_NONE;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/xrp_decode.sv
module xrp_decode
    import xrp_pkg::*;
(
    input  logic [7:0] ofs,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       bank,
    output acc_t       acc
);

    always_comb begin
        acc.tgt = map_offset(ofs, bank);
        acc.wr  = wr_en;
        acc.rd  = rd_en;
    end

endmodule

// File: rtl/xrp_ptr.sv
module xrp_ptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          step,
    input  logic [7:0]    din,
    output logic [AW-1:0] ptr
);

    localparam int HW = AW - 8;
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ld_lo) begin
            ptr_q[7:0] <= din;
        end else if (ld_hi) begin
            ptr_q[AW-1:8] <= din[HW-1:0];
        end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

    // R1: pointer cleared by reset
    assert_ptr_reset_R1: assert property (@(posedge clk) rst |=> ptr_q == '0);

    // R4: low byte load lands in bits 7:0, upper bits untouched
    assert_lo_load_R4: assert property (@(posedge clk) disable iff (rst)
        ld_lo |=> (ptr_q[7:0] == $past(din)) && (ptr_q[AW-1:8] == $past(ptr_q[AW-1:8])));

    // R6: no step, no load -> pointer holds
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!step && !ld_lo && !ld_hi) |=> ptr_q == $past(ptr_q));

    // R7: step below the top address advances by one
    assert_step_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_lo && !ld_hi && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);

    // R8: step at the top address wraps to zero
    assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_lo && !ld_hi && ptr_q == LAST) |=> ptr_q == '0);

endmodule

// File: rtl/xrp_ram.sv
module xrp_ram #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout
);

    logic [7:0] mem [DEPTH];
    logic [7:0] dout_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            dout_q <= mem[addr];
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/xram_port.sv
module xram_port
    import xrp_pkg::*;
#(
    parameter int RAM_BYTES = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bus_addr,
    input  logic [7:0] wr_data,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic [7:0] rd_data
);

    localparam int AW = $clog2(RAM_BYTES);
    localparam int HW = AW - 8;

    logic [7:0]    ctrl_q;
    logic          burst_q;
    logic [AW-1:0] ptr;
    acc_t          acc;
    logic          port_hit;
    logic          port_wr;
    logic          port_rd;
    logic          step;
    logic [7:0]    reg_val;
    logic [7:0]    reg_rd_q;
    logic          from_ram_q;
    logic [7:0]    ram_q;

    xrp_decode u_decode (
        .ofs   (bus_addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .bank  (ctrl_q[BANK_BIT]),
        .acc   (acc)
    );

    assign port_hit = (acc.tgt == TGT_PORT);
    assign port_wr  = port_hit && acc.wr;
    assign port_rd  = port_hit && acc.rd;
    assign step     = burst_q && (port_wr || port_rd);

    xrp_ptr #(.AW(AW)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .ld_lo (acc.wr && acc.tgt == TGT_PLO),
        .ld_hi (acc.wr && acc.tgt == TGT_PHI),
        .step  (step),
        .din   (wr_data),
        .ptr   (ptr)
    );

    xrp_ram #(.DEPTH(RAM_BYTES), .AW(AW)) u_ram (
        .clk  (clk),
        .we   (port_wr),
        .re   (port_rd),
        .addr (ptr),
        .din  (wr_data),
        .dout (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            burst_q <= 1'b0;
        end else if (acc.wr) begin
            if (acc.tgt == TGT_CTRL) begin
                ctrl_q <= wr_data;
            end
            if (acc.tgt == TGT_XCFG) begin
                burst_q <= wr_data[BURST_BIT];
            end
        end
    end

    always_comb begin
        reg_val = '0;
        unique case (acc.tgt)
            TGT_CTRL: reg_val = ctrl_q;
            TGT_XCFG: reg_val[BURST_BIT] = burst_q;
            TGT_PLO:  reg_val = ptr[7:0];
            TGT_PHI:  reg_val[HW-1:0] = ptr[AW-1:8];
            default:  reg_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rd_q   <= '0;
            from_ram_q <= 1'b0;
        end else if (acc.rd) begin
            reg_rd_q   <= reg_val;
            from_ram_q <= port_hit;
        end
    end

    assign rd_data = from_ram_q ? ram_q : reg_rd_q;

    // R1: reset clears the control byte and the read data
    assert_ctrl_reset_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == 8'h00) && !burst_q && (rd_data == 8'h00));

    // R3: banked offsets read as zero while bank select is 0
    assert_bank0_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ctrl_q[BANK_BIT] &&
         (bus_addr == OFS_XCFG || bus_addr == OFS_PLO ||
          bus_addr == OFS_PHI  || bus_addr == OFS_PORT)) |=> rd_data == 8'h00);

    // R3: banked writes leave burst enable alone while bank select is 0
    assert_bank0_burst_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ctrl_q[BANK_BIT]) |=> burst_q == $past(burst_q));

    // R5: read data holds without a read strobe
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R9: burst enable follows bit 5 of a bank-1 write to 0x4A
    assert_burst_load_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctrl_q[BANK_BIT] && bus_addr == OFS_XCFG) |=> burst_q == $past(wr_data[BURST_BIT]));

endmodule

// File: tb/test_xram_port.sv
module test_xram_port;

    localparam int RAM_BYTES = 2048;
    localparam int LAST = RAM_BYTES - 1;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic [7:0] wr_data;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_mem [RAM_BYTES];
    logic [7:0] m_ctrl;
    logic       m_burst;
    int         m_ptr;

    always #2 clk = ~clk;

    xram_port #(.RAM_BYTES(RAM_BYTES)) i_xram_port (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rd_data  (rd_data)
    );

    function automatic bit m_bank();
        return m_ctrl[4];
    endfunction

    function automatic logic [7:0] m_expect(input logic [7:0] a);
        if (a == 8'h0A) return m_ctrl;
        if (!m_bank()) return 8'h00;
        case (a)
            8'h4A:   return {2'b00, m_burst, 5'b00000};
            8'h50:   return m_ptr[7:0];
            8'h51:   return {5'b00000, m_ptr[10:8]};
            8'h53:   return m_mem[m_ptr];
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h0A) begin
            m_ctrl = d;
        end else if (m_bank()) begin
            case (a)
                8'h4A: m_burst = d[5];
                8'h50: m_ptr = (m_ptr & 32'h700) | int'(d);
                8'h51: m_ptr = (m_ptr & 32'h0FF) | (int'(d[2:0]) << 8);
                8'h53: begin
                    m_mem[m_ptr] = d;
                    if (m_burst) m_ptr = (m_ptr + 1) % RAM_BYTES;
                end
                default: ;
            endcase
        end
    endfunction

    function automatic void m_after_read(input logic [7:0] a);
        if (m_bank() && a == 8'h53 && m_burst) m_ptr = (m_ptr + 1) % RAM_BYTES;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        m_write(a, d);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        rd_en    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        logic [7:0] v;
        logic [7:0] e;
        e = m_expect(a);
        bus_rd(a, v);
        m_after_read(a);
        check(tag, v, e);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        bus_addr = '0; wr_data = '0; wr_en = 1'b0; rd_en = 1'b0;
        rst = 1'b1;
        m_ctrl = '0; m_burst = 1'b0; m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 8'h00);
        rst = 1'b0;

        // R1 reset state through the bus
        rd_chk("R1 ctrl after reset", 8'h0A);
        bus_wr(8'h0A, 8'h10);
        rd_chk("R1 ptr lo after reset", 8'h50);
        rd_chk("R1 ptr hi after reset", 8'h51);
        rd_chk("R1 burst after reset", 8'h4A);

        // R2 full control byte
        bus_wr(8'h0A, 8'hA5);
        rd_chk("R2 ctrl readback bank0", 8'h0A);
        bus_wr(8'h0A, 8'h5A);
        rd_chk("R2 ctrl readback bank1", 8'h0A);

        // R10 / R6 / R7 / R8: fill whole RAM by burst, crossing the top
        bus_wr(8'h4A, 8'hFF);
        rd_chk("R9 burst bit only", 8'h4A);
        bus_wr(8'h50, 8'hFF);
        bus_wr(8'h51, 8'hFF);
        rd_chk("R4 hi byte masked", 8'h51);
        rd_chk("R4 lo byte", 8'h50);
        for (int i = 0; i < RAM_BYTES; i++) begin
            bus_wr(8'h53, 8'((i * 37 + 11) ^ (i >> 8)));
        end
        rd_chk("R8 ptr lo after wrap", 8'h50);
        rd_chk("R8 ptr hi after wrap", 8'h51);

        // R6: burst off, repeated reads hit same byte
        bus_wr(8'h4A, 8'h00);
        bus_wr(8'h50, 8'h00);
        bus_wr(8'h51, 8'h00);
        rd_chk("R8 wrapped write landed at 0", 8'h53);
        rd_chk("R6 same byte again", 8'h53);
        rd_chk("R6 ptr unchanged", 8'h50);
        bus_wr(8'h50, 8'hFF);
        bus_wr(8'h51, 8'h07);
        rd_chk("R10 first burst write at loaded top", 8'h53);

        // R7: burst read increments after access
        bus_wr(8'h4A, 8'h20);
        bus_wr(8'h50, 8'h10);
        bus_wr(8'h51, 8'h00);
        rd_chk("R7 burst read first", 8'h53);
        rd_chk("R7 burst read second", 8'h53);
        rd_chk("R7 ptr advanced by two", 8'h50);

        // R3: bank 0 gating
        bus_wr(8'h0A, 8'h00);
        bus_wr(8'h50, 8'h33);
        bus_wr(8'h51, 8'h02);
        bus_wr(8'h4A, 8'h00);
        bus_wr(8'h53, 8'hEE);
        rd_chk("R3 port reads zero", 8'h53);
        rd_chk("R3 lo reads zero", 8'h50);
        rd_chk("R3 cfg reads zero", 8'h4A);
        bus_wr(8'h0A, 8'h10);
        rd_chk("R3 ptr lo untouched", 8'h50);
        rd_chk("R3 ptr hi untouched", 8'h51);
        rd_chk("R3 burst untouched", 8'h4A);
        rd_chk("R3 ram byte untouched", 8'h53);

        // R11: unmapped offsets
        bus_wr(8'h52, 8'h77);
        rd_chk("R11 unmapped 0x52", 8'h52);
        rd_chk("R11 unmapped 0x0B", 8'h0B);
        rd_chk("R11 state after unmapped write", 8'h50);

        // R5: rd_data holds without strobe
        rd_chk("R5 read before idle", 8'h0A);
        v = rd_data;
        bus_wr(8'h0A, 8'h13);
        repeat (3) @(negedge clk);
        check("R5 rd_data holds", rd_data, v);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 9);
            d  = 8'($urandom);
            case (op)
                0: bus_wr(8'h0A, ($urandom_range(0, 3) != 0) ? (d | 8'h10) : (d & 8'hEF));
                1: bus_wr(8'h4A, d);
                2: bus_wr(8'h50, d);
                3: bus_wr(8'h51, d);
                4, 5: bus_wr(8'h53, d);
                6, 7: rd_chk("R7 R10 random port read", 8'h53);
                8: rd_chk("R4 random ptr read", ($urandom_range(0, 1) != 0) ? 8'h50 : 8'h51);
                default: rd_chk("R11 R9 random reg read", ($urandom_range(0, 1) != 0) ? 8'h4A : 8'h60);
            endcase
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule